// File: doc/BRIEF.md
# Reconfigurable Serial-by-Parallel Multiplier

This block forms the product of a bit-serial multiplicand A and a stored parallel multiplier B. A enters least significant bit first, one bit per clock, and may be any length m. Its final bit is marked by a flag. B is captured in parallel when an operation starts. The product leaves on a serial output, one bit per clock and least significant bit first. It is m+n bits long, where n is the selected width of B.

The datapath is a row of 4-bit slices. Each slice holds a ripple-carry adder and a 4-bit section of the running partial sum. Routing logic between adjacent slices either passes carry and shift bits across the boundary or cuts them. The slices therefore work as four independent 4-bit lanes, as two 8-bit lanes, or as one 16-bit lane. A narrow setting gives more products per operation, and a wide setting gives more precision.

A sign control selects unsigned or two's-complement arithmetic. In signed mode, B is sign-extended at the top of its lane. The row of the final A bit is subtracted: it is added inverted, with a carry-in of one. After the last A bit, the block runs n flush cycles to empty the remaining high bits.

Top module: `sp_multiprec_mul`

## Requirements
- R1: After reset, ready is 1, and p_valid, p_last and every p_bit are 0.
- R2: In unsigned mode, each active lane emits the m+n low bits of A*B, least significant first. Product bit k is on p_bit in the cycle after A bit k was presented. The result takes exactly m+n p_valid cycles.
- R3: When signed_en was 1 at start, A (m bits) and B (n bits) are two's-complement. The m+n emitted bits equal the low m+n bits of the signed product.
- R4: prec_sel 0 gives four independent 4-bit lanes. Lane k takes a_bit[k] and b_in[4k+3:4k] and drives p_bit[k].
- R5: prec_sel 1 gives two 8-bit lanes, led by slices 0 and 2 with B bits [7:0] and [15:8]. p_bit[1] and p_bit[3] stay 0, and a_bit[1] and a_bit[3] have no effect.
- R6: prec_sel 2 and 3 both give one 16-bit lane on slice 0. p_bit[3:1] stay 0, and a_bit[3:1] have no effect.
- R7: p_last is 1 only with the final product bit. ready returns to 1 in that same cycle.
- R8: prec_sel, signed_en and b_in are sampled only when start is seen with ready at 1. Changes to them, and start pulses while ready is 0, have no effect on the running product.
- R9: With m=1 in signed mode, the single A bit is the sign bit, so A is 0 or -1.
- R10: a_bit and a_last in the start cycle have no effect. A bit 0 is taken in the cycle after start. a_bit is ignored during the flush cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only while ready |
| ready | output | 1 | Block idle and able to accept start |
| prec_sel | input | 2 | Lane width: 0 = 4, 1 = 8, 2 or 3 = 16 bits |
| signed_en | input | 1 | 1 = two's-complement, 0 = unsigned |
| b_in | input | 16 | Parallel multiplier, captured at start |
| a_bit | input | 4 | Serial multiplicand bit for each lane, LSB first |
| a_last | input | 1 | Marks the final A bit, shared by all lanes |
| p_bit | output | 4 | Serial product bit for each lane, LSB first |
| p_valid | output | 1 | p_bit carries a product bit |
| p_last | output | 1 | Final product bit of the operation |

## Verification
Two events can fall in the same cycle: the first row of the product and the subtracted sign row. This happens when m=1 in signed mode, so the inverted row and its carry-in of one meet an empty running sum. The bench provokes this at every lane width and compares the result with the product of 0 or -1 and B. A second coincidence is captured configuration against live inputs. The bench drives new settings, a fresh B and a stray start while an operation runs, and expects the product of the values held at start.

// File: rtl/spm_pkg.sv
package spm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FEED  = 2'd1,
      ST_FLUSH = 2'd2
   } spm_state_e;

   // width in bits of one lane made of 2**lvl slices
   function automatic int lane_bits(input int slice_w, input int lvl);
      return slice_w << lvl;
   endfunction

endpackage

// File: rtl/spm_ctrl.sv
module spm_ctrl
   import spm_pkg::*;
#(
   parameter  int SLICE_W    = 4,
   parameter  int NUM_SLICES = 4,
   localparam int LVL        = $clog2(NUM_SLICES),
   localparam int SEL_W      = (LVL < 1) ? 1 : $clog2(LVL + 1),
   localparam int TOT_W      = SLICE_W * NUM_SLICES,
   localparam int CNT_W      = $clog2(TOT_W)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SEL_W-1:0] prec_sel,
   input  logic             signed_en,
   input  logic             a_last,
   output logic             ready,
   output logic             load,
   output logic             run,
   output logic             feed,
   output logic             inv,
   output logic             fin,
   output logic [SEL_W-1:0] lvl_q,
   output logic             sgn_q
);

   spm_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;
   logic [SEL_W-1:0] lvl_clamped;

   always_comb begin
      term = CNT_W'(lane_bits(SLICE_W, int'(lvl_q)) - 1);
      if (int'(prec_sel) > LVL)
         lvl_clamped = SEL_W'(LVL);
      else
         lvl_clamped = prec_sel;
   end

   assign ready = (st_q == ST_IDLE);
   assign load  = start && (st_q == ST_IDLE);
   assign run   = (st_q != ST_IDLE);
   assign feed  = (st_q == ST_FEED);
   assign inv   = feed && sgn_q && a_last;
   assign fin   = (st_q == ST_FLUSH) && (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         lvl_q <= '0;
         sgn_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q  <= ST_FEED;
                  lvl_q <= lvl_clamped;
                  sgn_q <= signed_en;
               end
            end
            ST_FEED: begin
               if (a_last) begin
                  st_q  <= ST_FLUSH;
                  cnt_q <= '0;
               end
            end
            ST_FLUSH: begin
               if (cnt_q == term)
                  st_q <= ST_IDLE;
               else
                  cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spm_switch.sv
module spm_switch #(
   parameter  int NUM_SLICES = 4,
   parameter  int SEL_W      = 2,
   localparam int IDX_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
)(
   input  logic [SEL_W-1:0]      lvl,
   input  logic                  a_gate,
   input  logic                  inv,
   input  logic [NUM_SLICES-1:0] a_bit,
   input  logic [NUM_SLICES-1:0] cout,
   input  logic [NUM_SLICES-1:0] t0,
   input  logic [NUM_SLICES-1:0] ext,
   output logic [NUM_SLICES-1:0] a_eff,
   output logic [NUM_SLICES-1:0] cin,
   output logic [NUM_SLICES-1:0] shin,
   output logic [NUM_SLICES-1:0] lead
);

   logic [IDX_W-1:0] gmask;

   always_comb gmask = IDX_W'((1 << lvl) - 1);

   for (genvar k = 0; k < NUM_SLICES; k++) begin : g_link
      localparam logic [IDX_W-1:0] KI = IDX_W'(k);
      logic [IDX_W-1:0] base;

      assign base     = KI & ~gmask;
      assign lead[k]  = ((KI & gmask) == '0);
      assign a_eff[k] = a_gate & a_bit[base];

      // carry path: cut at a lane's lowest slice, where the sign row carry enters
      if (k == 0) begin : g_cin_first
         assign cin[k] = a_eff[k] & inv;
      end else begin : g_cin_chain
         assign cin[k] = lead[k] ? (a_eff[k] & inv) : cout[k-1];
      end

      // shift path: a lane's top slice refills from its own extension bit
      if (k == NUM_SLICES - 1) begin : g_sh_last
         assign shin[k] = ext[k];
      end else begin : g_sh_chain
         logic top_k;
         assign top_k   = ((KI & gmask) == gmask);
         assign shin[k] = top_k ? ext[k] : t0[k+1];
      end
   end

endmodule

// File: rtl/spm_slice.sv
module spm_slice #(
   parameter int SLICE_W = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               en,
   input  logic               a,
   input  logic               inv,
   input  logic               sgn,
   input  logic [SLICE_W-1:0] b,
   input  logic               cin,
   input  logic               shin,
   output logic               t0,
   output logic               cout,
   output logic               ext
);

   logic [SLICE_W-1:0] r_q;
   logic [SLICE_W-1:0] pp;
   logic [SLICE_W:0]   sum;

   always_comb begin
      pp   = {SLICE_W{a}} & (b ^ {SLICE_W{inv}});
      sum  = {1'b0, r_q} + {1'b0, pp} + (SLICE_W+1)'(cin);
      t0   = sum[0];
      cout = sum[SLICE_W];
      // bit above the slice, valid when this slice is the top of its lane
      ext  = (sgn & r_q[SLICE_W-1]) ^ (sgn & pp[SLICE_W-1]) ^ sum[SLICE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         r_q <= '0;
      else if (clr)
         r_q <= '0;
      else if (en)
         r_q <= {shin, sum[SLICE_W-1:1]};
   end

endmodule

// File: rtl/sp_multiprec_mul.sv
module sp_multiprec_mul #(
   parameter  int SLICE_W    = 4,
   parameter  int NUM_SLICES = 4,
   localparam int LVL        = $clog2(NUM_SLICES),
   localparam int SEL_W      = (LVL < 1) ? 1 : $clog2(LVL + 1),
   localparam int TOT_W      = SLICE_W * NUM_SLICES
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   output logic                  ready,
   input  logic [SEL_W-1:0]      prec_sel,
   input  logic                  signed_en,
   input  logic [TOT_W-1:0]      b_in,
   input  logic [NUM_SLICES-1:0] a_bit,
   input  logic                  a_last,
   output logic [NUM_SLICES-1:0] p_bit,
   output logic                  p_valid,
   output logic                  p_last
);

   if (SLICE_W < 2) begin : g_chk_w
      $error("SLICE_W must be at least 2");
   end
   if (NUM_SLICES < 2 || (NUM_SLICES & (NUM_SLICES - 1)) != 0) begin : g_chk_n
      $error("NUM_SLICES must be a power of two, at least 2");
   end

   logic                  load, run, feed, inv, fin, sgn_q;
   logic [SEL_W-1:0]      lvl_q;
   logic [TOT_W-1:0]      b_q;
   logic [NUM_SLICES-1:0] a_eff, cin, shin, lead, t0, cout, ext;
   logic [NUM_SLICES-1:0] p_bit_q;
   logic                  p_valid_q, p_last_q;

   spm_ctrl #(
      .SLICE_W    (SLICE_W),
      .NUM_SLICES (NUM_SLICES)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .prec_sel  (prec_sel),
      .signed_en (signed_en),
      .a_last    (a_last),
      .ready     (ready),
      .load      (load),
      .run       (run),
      .feed      (feed),
      .inv       (inv),
      .fin       (fin),
      .lvl_q     (lvl_q),
      .sgn_q     (sgn_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         b_q <= '0;
      else if (load)
         b_q <= b_in;
   end

   spm_switch #(
      .NUM_SLICES (NUM_SLICES),
      .SEL_W      (SEL_W)
   ) sw_i (
      .lvl    (lvl_q),
      .a_gate (feed),
      .inv    (inv),
      .a_bit  (a_bit),
      .cout   (cout),
      .t0     (t0),
      .ext    (ext),
      .a_eff  (a_eff),
      .cin    (cin),
      .shin   (shin),
      .lead   (lead)
   );

   for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
      spm_slice #(
         .SLICE_W (SLICE_W)
      ) slice_i (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (load),
         .en    (run),
         .a     (a_eff[k]),
         .inv   (inv),
         .sgn   (sgn_q),
         .b     (b_q[k*SLICE_W +: SLICE_W]),
         .cin   (cin[k]),
         .shin  (shin[k]),
         .t0    (t0[k]),
         .cout  (cout[k]),
         .ext   (ext[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_bit_q   <= '0;
         p_valid_q <= 1'b0;
         p_last_q  <= 1'b0;
      end else begin
         p_bit_q   <= run ? (t0 & lead) : '0;
         p_valid_q <= run;
         p_last_q  <= fin;
      end
   end

   assign p_bit   = p_bit_q;
   assign p_valid = p_valid_q;
   assign p_last  = p_last_q;

endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
   parameter  int SLICE_W    = 4,
   parameter  int NUM_SLICES = 4,
   localparam int LVL        = $clog2(NUM_SLICES),
   localparam int SEL_W      = (LVL < 1) ? 1 : $clog2(LVL + 1),
   localparam int TOT_W      = SLICE_W * NUM_SLICES
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start,
   input logic                  ready,
   input logic                  p_valid,
   input logic                  p_last,
   input logic [NUM_SLICES-1:0] p_bit,
   input logic [SEL_W-1:0]      lvl_q,
   input logic                  sgn_q,
   input logic [TOT_W-1:0]      b_q
);

   logic [NUM_SLICES-1:0] follower;

   always_comb begin
      for (int k = 0; k < NUM_SLICES; k++)
         follower[k] = (k % (1 << lvl_q)) != 0;
   end

   AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> (!ready && !p_valid)); // R2

   AST_READY_ONLY_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && p_valid) |-> p_last); // R7

   AST_LAST_FREES_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      p_last |-> (p_valid && ready)); // R7

   AST_CFG_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> ($stable(lvl_q) && $stable(sgn_q) && $stable(b_q))); // R8

   AST_FOLLOWER_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      p_valid |-> ((p_bit & follower) == '0)); // R5, R6

endmodule

bind sp_multiprec_mul spm_checker #(
   .SLICE_W    (SLICE_W),
   .NUM_SLICES (NUM_SLICES)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .ready   (ready),
   .p_valid (p_valid),
   .p_last  (p_last),
   .p_bit   (p_bit),
   .lvl_q   (lvl_q),
   .sgn_q   (sgn_q),
   .b_q     (b_q)
);

// File: tb/sp_multiprec_mul_tb_top.sv
module sp_multiprec_mul_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        ready;
   logic [1:0]  prec_sel = '0;
   logic        signed_en = 1'b0;
   logic [15:0] b_in = '0;
   logic [3:0]  a_bit = '0;
   logic        a_last = 1'b0;
   logic [3:0]  p_bit;
   logic        p_valid;
   logic        p_last;

   int n_run  = 0;
   int n_fail = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #2 clk = ~clk;

   sp_multiprec_mul dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ready     (ready),
      .prec_sel  (prec_sel),
      .signed_en (signed_en),
      .b_in      (b_in),
      .a_bit     (a_bit),
      .a_last    (a_last),
      .p_bit     (p_bit),
      .p_valid   (p_valid),
      .p_last    (p_last)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   // one operation; a4 holds 16 A bits for each of the four lanes
   task automatic run_op(input int prec, input bit sgn, input logic [15:0] b,
                         input logic [63:0] a4, input int m, input bit disturb,
                         input string req);
      int lvl = (prec > 2) ? 2 : prec;
      int g   = 1 << lvl;
      int n   = 4 * g;
      logic [31:0] got [4];
      int cnt = 0;
      int last_pos = -1;
      bit follower_bad = 1'b0;
      for (int l = 0; l < 4; l++) got[l] = '0;
      @(negedge clk);
      start     = 1'b1;
      prec_sel  = 2'(prec);
      signed_en = sgn;
      b_in      = b;
      a_bit     = 4'hF;   // start-cycle junk (R10)
      a_last    = 1'b1;
      for (int cyc = 0; cyc < m + n + 3; cyc++) begin
         @(negedge clk);
         if (p_valid) begin
            for (int l = 0; l < 4; l++) begin
               got[l][cnt] = p_bit[l];
               if ((l % g) != 0 && p_bit[l]) follower_bad = 1'b1;
            end
            if (p_last) last_pos = cnt;
            cnt++;
         end
         start = 1'b0;
         if (disturb) begin
            prec_sel  = ~2'(prec);
            signed_en = ~sgn;
            b_in      = ~b;
            if (cyc == 2) start = 1'b1;   // stray start while busy (R8)
         end
         for (int l = 0; l < 4; l++) begin
            if (cyc < m && (l % g) == 0)
               a_bit[l] = a4[16*l + cyc];
            else
               a_bit[l] = ~a4[16*l + (cyc % 16)];   // ignored inputs
         end
         a_last = (cyc == m - 1);
      end
      start  = 1'b0;
      a_last = 1'b0;
      check(cnt == m + n, "R2 R7 bit count", cnt, m + n);
      check(last_pos == m + n - 1, "R7 last marker", last_pos, m + n - 1);
      check(!follower_bad, (g == 2) ? "R5 follower lanes" : "R6 R4 follower lanes",
            follower_bad, 0);
      for (int l = 0; l < 4; l += g) begin
         longint av = 0, bv = 0, pr, mask;
         for (int i = 0; i < m; i++) av |= longint'(a4[16*l + i]) << i;
         for (int i = 0; i < n; i++) bv |= longint'(b[4*l + i]) << i;
         if (sgn && a4[16*l + m - 1]) av -= (longint'(1) << m);
         if (sgn && b[4*l + n - 1])   bv -= (longint'(1) << n);
         mask = (longint'(1) << (m + n)) - 1;
         pr   = (av * bv) & mask;
         check((longint'(got[l]) & mask) == pr, req, longint'(got[l]) & mask, pr);
      end
   endtask

   initial begin
      #(4 * 150000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready == 1'b1, "R1 ready", ready, 1);
      check(p_valid == 1'b0 && p_last == 1'b0, "R1 valid/last", {p_valid, p_last}, 0);
      check(p_bit == 4'h0, "R1 p_bit", p_bit, 0);

      // R4 with R2/R3: exhaustive 4-bit sweep, different value per lane
      for (int b = 0; b < 16; b++)
         for (int a = 0; a < 16; a++)
            for (int s = 0; s < 2; s++) begin
               logic [15:0] bv;
               logic [63:0] av = '0;
               for (int l = 0; l < 4; l++) begin
                  bv[4*l +: 4]  = 4'((b + 5*l) & 15);
                  av[16*l +: 16] = 16'((a + 7*l) & 15);
               end
               run_op(0, s[0], bv, av, 4, 1'b0, s ? "R3 R4 signed 4-bit" : "R2 R4 unsigned 4-bit");
            end

      // R10: varying A length in split mode, junk in the start cycle
      for (int t = 0; t < 24; t++) begin
         seed = nxt(seed);
         run_op(0, t[0], seed[15:0], {seed, nxt(seed)}, 1 + (t % 9), 1'b0, "R10 R4 split lengths");
      end

      // R5: two 8-bit lanes
      for (int t = 0; t < 60; t++) begin
         logic [63:0] av;
         seed = nxt(seed);
         av = {seed, nxt(seed)};
         seed = nxt(seed);
         run_op(1, t[0], seed[15:0], av, 1 + (t % 12), 1'b0, "R5 8-bit lanes");
      end

      // R6: single 16-bit lane, codes 2 and 3
      for (int t = 0; t < 60; t++) begin
         logic [63:0] av;
         seed = nxt(seed);
         av = {seed, nxt(seed)};
         seed = nxt(seed);
         run_op(2 + (t % 2), t[1], seed[15:0], av, 1 + (t % 14), 1'b0, "R6 16-bit lane");
      end

      // R9: one-bit signed A at every width
      for (int p = 0; p < 3; p++)
         for (int t = 0; t < 6; t++) begin
            logic [15:0] bv = 16'(16'h8001 + 16'h1357 * t);
            run_op(p, 1'b1, bv, {4{16'(t % 2 == 0 ? 16'h0001 : 16'h0000)}} ^ 64'(t / 2), 1,
                   1'b0, "R9 one-bit signed");
         end

      // R8: inputs changed and stray start during the operation
      for (int t = 0; t < 12; t++) begin
         logic [63:0] av;
         seed = nxt(seed);
         av = {seed, nxt(seed)};
         seed = nxt(seed);
         run_op(t % 3, t[0], seed[15:0], av, 2 + (t % 7), 1'b1, "R8 held configuration");
      end

      repeat (4) @(negedge clk);
      check(ready == 1'b1 && p_valid == 1'b0, "R7 idle after run", {ready, p_valid}, 2);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule